// File: doc/BRIEF.md
# Digital Potentiometer Wiper Register and Retained-Setting Sequencer

This block keeps the tap code of a 128-step digital potentiometer. It holds three registers: a volatile wiper code that drives the tap selection, a retained start-up code that models a non-volatile cell as a flop outside the normal reset, and an 8-bit control register. An SPI front end presents decoded one-cycle read and write requests on a two-bit register address, and it pulses `cs_rise` when chip select returns high.

After reset the wiper is parked at midscale. A recall timer then copies the retained start-up code into the wiper. Requests are refused until that copy has finished. A write to the wiper address with the volatile-select bit clear updates the wiper at once and arms a retained-cell write. That write starts on the next chip-select rise. A self-timed busy window follows, and during it writes to the wiper and to the control register are dropped. The shutdown output is raised by a low shutdown pin or by a cleared run bit. The wiper code is kept through shutdown so that the tap returns to the same position when shutdown ends.

Top module: `wiper_nv_ctrl`

## Requirements
- R1: While `rst_n` is low, and until the recall completes, `wiper_code_o` is midscale (40h), `ready_o` is 0 and the control register reads 40h.
- R2: Exactly RECALL_CYC rising clock edges after `rst_n` goes high, `wiper_code_o` takes the retained start-up code and `ready_o` rises.
- R3: Requests made while `ready_o` is 0 are ignored. No read data is returned (`rd_valid_o` stays 0), no register changes, and no retained-cell write can be in progress.
- R4: With the volatile-select bit (control bit 7) at 1, a write to address 00b changes only the wiper code. The retained code is unchanged.
- R5: With control bit 7 at 0, a write to address 00b loads the wiper code in the same cycle and arms a retained write. Reading address 00b in this mode returns the retained code and leaves the wiper code as it is.
- R6: A `cs_rise` pulse while a retained write is armed sets the busy bit (control bit 5) for exactly WC_CYC cycles. The retained code takes the new value when the busy window ends and at no other time, apart from `ret_rst_n`.
- R7: While the busy bit is 1, writes to address 00b and to the control register are dropped. This includes a new retained-write request, which is not queued.
- R8: The control register is at address 10b. Bit 7 is volatile select, bit 6 is run (1 = operating) and bit 5 is busy. Bit 5 and bits [4:0] are read-only, and bits [4:0] read 0. Addresses 01b and 11b read 00h and ignore writes.
- R9: `shutdown_o` is 1 when `shdn_pin_n` is 0 or control bit 6 is 0. The wiper code is kept, and all registers stay readable and writable, during shutdown.
- R10: Read data appears on `rd_data_o` with `rd_valid_o` high on the cycle after an accepted read. Address 00b returns the selected 7-bit code zero-extended.
- R11: Pulsing `rst_n` alone preserves the retained code, so the recall restores the last committed value. `ret_rst_n` reloads the factory value IVR_FACTORY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-up reset (volatile state) |
| ret_rst_n | input | 1 | Active-low reset of the retained start-up code |
| shdn_pin_n | input | 1 | Active-low shutdown pin |
| req_valid | input | 1 | One-cycle register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address |
| req_wdata | input | 8 | Write data |
| cs_rise | input | 1 | Pulse on chip-select rising edge |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Read data |
| ready_o | output | 1 | Recall finished, requests accepted |
| wiper_code_o | output | 7 | Tap code, 00h nearest ground, 7Fh nearest supply |
| shutdown_o | output | 1 | Potentiometer in shutdown |

## Verification
The following properties are checked on every cycle:
- The wiper is held at midscale and no busy window can exist before recall.
- The wiper code and the control bits are frozen during a busy window.
- The retained code moves only when a busy window closes.
- Read data follows an accepted read by one cycle.
- A low shutdown pin always shows on the shutdown output.

Only the bench's scenarios can show the following:
- The exact recall and busy window lengths.
- The read-back layout of the control register.
- Which code is recalled after a volatile-only reset.
- That the wiper comes back unchanged after shutdown.

// File: rtl/wnv_pkg.sv
package wnv_pkg;
   localparam logic [1:0] ADDR_CODE = 2'b00;
   localparam logic [1:0] ADDR_CTRL = 2'b10;
endpackage

// File: rtl/wnv_timer.sv
module wnv_timer #(
   parameter int unsigned CYCLES       = 4,
   parameter bit          ARM_AT_RESET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic last
);
   localparam int unsigned CW = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("wnv_timer: CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ARM_AT_RESET ? CW'(CYCLES) : '0;
      end else if (start && cnt_q == '0) begin
         cnt_q <= CW'(CYCLES);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);
   assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/wnv_ctrl_reg.sv
module wnv_ctrl_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic vol_d,
   input  logic run_d,
   output logic vol_q,
   output logic run_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vol_q <= 1'b0;
         run_q <= 1'b1;
      end else if (wr_en) begin
         vol_q <= vol_d;
         run_q <= run_d;
      end
   end
endmodule

// File: rtl/wiper_nv_ctrl.sv
module wiper_nv_ctrl #(
   parameter int unsigned CODE_W      = 7,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned WC_CYC      = 1000000,
   parameter int unsigned RECALL_CYC  = 64,
   parameter int unsigned IVR_FACTORY = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ret_rst_n,
   input  logic              shdn_pin_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              cs_rise,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              ready_o,
   output logic [CODE_W-1:0] wiper_code_o,
   output logic              shutdown_o
);
   import wnv_pkg::*;

   localparam logic [CODE_W-1:0] MIDSCALE = CODE_W'(1) << (CODE_W - 1);
   localparam logic [CODE_W-1:0] FACTORY  = CODE_W'(IVR_FACTORY);

   generate
      if (DATA_W != CODE_W + 1) begin : g_bad_width
         $error("wiper_nv_ctrl: DATA_W must be CODE_W + 1");
      end
      if (IVR_FACTORY >= (1 << CODE_W)) begin : g_bad_factory
         $error("wiper_nv_ctrl: IVR_FACTORY does not fit CODE_W");
      end
   endgenerate

   logic              recall_busy, recall_last;
   logic              wip, wc_last, wc_start;
   logic              ctrl_vol, ctrl_run;
   logic              accept, wr_ok, wr_code, wr_ctrl;
   logic              nv_armed;
   logic [CODE_W-1:0] nv_pend;
   logic [CODE_W-1:0] wr_q;
   logic [CODE_W-1:0] ivr_q;
   logic [DATA_W-1:0] rd_mux;

   wnv_timer #(.CYCLES(RECALL_CYC), .ARM_AT_RESET(1'b1)) u_recall (
      .clk(clk), .rst_n(rst_n), .start(1'b0),
      .busy(recall_busy), .last(recall_last)
   );

   assign wc_start = cs_rise && nv_armed && !wip;

   wnv_timer #(.CYCLES(WC_CYC), .ARM_AT_RESET(1'b0)) u_wcycle (
      .clk(clk), .rst_n(rst_n), .start(wc_start),
      .busy(wip), .last(wc_last)
   );

   assign ready_o = !recall_busy;
   assign accept  = req_valid && ready_o;
   assign wr_ok   = accept && req_write && !wip;
   assign wr_code = wr_ok && (req_addr == ADDR_CODE);
   assign wr_ctrl = wr_ok && (req_addr == ADDR_CTRL);

   wnv_ctrl_reg u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl),
      .vol_d(req_wdata[DATA_W-1]), .run_d(req_wdata[DATA_W-2]),
      .vol_q(ctrl_vol), .run_q(ctrl_run)
   );

   // Volatile tap code: midscale at reset, recalled copy, then writes.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= MIDSCALE;
      end else if (recall_last) begin
         wr_q <= ivr_q;
      end else if (wr_code) begin
         wr_q <= req_wdata[CODE_W-1:0];
      end
   end

   // Armed retained write waiting for the chip-select rise.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv_armed <= 1'b0;
         nv_pend  <= '0;
      end else if (wr_code && !ctrl_vol) begin
         nv_armed <= 1'b1;
         nv_pend  <= req_wdata[CODE_W-1:0];
      end else if (wc_start) begin
         nv_armed <= 1'b0;
      end
   end

   // Retained cell model: survives rst_n.
   always_ff @(posedge clk or negedge ret_rst_n) begin
      if (!ret_rst_n) begin
         ivr_q <= FACTORY;
      end else if (wc_last) begin
         ivr_q <= nv_pend;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (req_addr)
         ADDR_CODE: rd_mux[CODE_W-1:0] = ctrl_vol ? wr_q : ivr_q;
         ADDR_CTRL: begin
            rd_mux[DATA_W-1] = ctrl_vol;
            rd_mux[DATA_W-2] = ctrl_run;
            rd_mux[DATA_W-3] = wip;
         end
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= accept && !req_write;
         if (accept && !req_write) begin
            rd_data_o <= rd_mux;
         end
      end
   end

   assign wiper_code_o = wr_q;
   assign shutdown_o   = !shdn_pin_n || !ctrl_run;
endmodule

// File: rtl/wiper_nv_ctrl_chk.sv
module wiper_nv_ctrl_chk #(
   parameter int unsigned CODE_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ret_rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [1:0]        req_addr,
   input logic              shdn_pin_n,
   input logic              ready_o,
   input logic              rd_valid_o,
   input logic              shutdown_o,
   input logic [CODE_W-1:0] wiper_code_o,
   input logic              wip,
   input logic              ctrl_vol,
   input logic              ctrl_run,
   input logic [CODE_W-1:0] ivr_q
);
   localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

   assert_recall_midscale_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_o |-> wiper_code_o == MID);

   assert_no_busy_in_recall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_o |-> !wip);

   assert_ivr_only_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n || !ret_rst_n)
      !$past(wip) |-> $stable(ivr_q));

   assert_wiper_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wip && $past(wip)) |-> $stable(wiper_code_o));

   assert_ctrl_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wip && req_valid && req_write && req_addr == 2'b10) |=> ($stable(ctrl_vol) && $stable(ctrl_run)));

   assert_pin_shutdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !shdn_pin_n |-> shutdown_o);

   assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> $past(req_valid && !req_write && ready_o));
endmodule

bind wiper_nv_ctrl wiper_nv_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ret_rst_n(ret_rst_n),
   .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
   .shdn_pin_n(shdn_pin_n), .ready_o(ready_o), .rd_valid_o(rd_valid_o),
   .shutdown_o(shutdown_o), .wiper_code_o(wiper_code_o), .wip(wip),
   .ctrl_vol(ctrl_vol), .ctrl_run(ctrl_run), .ivr_q(ivr_q)
);

// File: tb/wiper_nv_ctrl_tb_top.sv
module wiper_nv_ctrl_tb_top;
   localparam int WC  = 20;
   localparam int RC  = 8;
   localparam int FAC = 'h15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0, ret_rst_n = 1'b0, shdn_pin_n = 1'b1;
   logic       req_valid = 1'b0, req_write = 1'b0, cs_rise = 1'b0;
   logic [1:0] req_addr = 2'b00;
   logic [7:0] req_wdata = 8'h00;
   logic       rd_valid_o, ready_o, shutdown_o;
   logic [7:0] rd_data_o;
   logic [6:0] wiper_code_o;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   wiper_nv_ctrl #(.WC_CYC(WC), .RECALL_CYC(RC), .IVR_FACTORY(FAC)) dut_i (
      .clk(clk), .rst_n(rst_n), .ret_rst_n(ret_rst_n), .shdn_pin_n(shdn_pin_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .cs_rise(cs_rise), .rd_valid_o(rd_valid_o),
      .rd_data_o(rd_data_o), .ready_o(ready_o), .wiper_code_o(wiper_code_o),
      .shutdown_o(shutdown_o)
   );

   typedef struct packed {
      logic       wr;
      logic [1:0] addr;
      logic [7:0] data;
      logic [7:0] exp_rd;
      logic [6:0] exp_wiper;
   } step_t;

   localparam int NSTEP = 14;
   localparam step_t STEPS [NSTEP] = '{
      '{1'b0, 2'b10, 8'h00, 8'h40, 7'h15},
      '{1'b0, 2'b00, 8'h00, 8'h15, 7'h15},
      '{1'b1, 2'b10, 8'hC0, 8'h00, 7'h15},
      '{1'b0, 2'b10, 8'h00, 8'hC0, 7'h15},
      '{1'b1, 2'b00, 8'h7F, 8'h00, 7'h7F},
      '{1'b0, 2'b00, 8'h00, 8'h7F, 7'h7F},
      '{1'b0, 2'b01, 8'h00, 8'h00, 7'h7F},
      '{1'b1, 2'b11, 8'h55, 8'h00, 7'h7F},
      '{1'b0, 2'b10, 8'h00, 8'hC0, 7'h7F},
      '{1'b1, 2'b10, 8'hE5, 8'h00, 7'h7F},
      '{1'b0, 2'b10, 8'h00, 8'hC0, 7'h7F},
      '{1'b1, 2'b10, 8'h40, 8'h00, 7'h7F},
      '{1'b1, 2'b00, 8'h00, 8'h00, 7'h00},
      '{1'b0, 2'b00, 8'h00, 8'h15, 7'h00}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Called at a negedge; consumes exactly one rising edge.
   task automatic do_req(input logic w, input logic [1:0] a, input logic [7:0] d);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic pulse_cs();
      cs_rise = 1'b1;
      @(negedge clk);
      cs_rise = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

   initial begin
      @(negedge clk);
      idle(3);
      chk("R1 wiper in reset", int'(wiper_code_o), 'h40);
      chk("R1 ready in reset", int'(ready_o), 0);
      rst_n = 1'b1; ret_rst_n = 1'b1;
      chk("R1 wiper after release", int'(wiper_code_o), 'h40);
      // edge 1 and 2: requests during recall
      do_req(1'b1, 2'b00, 8'h22);
      chk("R3 write ignored in recall", int'(wiper_code_o), 'h40);
      do_req(1'b0, 2'b10, 8'h00);
      chk("R3 no read data in recall", int'(rd_valid_o), 0);
      idle(RC - 3);
      chk("R2 not ready one edge early", int'(ready_o), 0);
      chk("R1 midscale until recall", int'(wiper_code_o), 'h40);
      idle(1);
      chk("R2 ready after recall", int'(ready_o), 1);
      chk("R2 recalled code", int'(wiper_code_o), FAC);
      chk("R9 no shutdown by default", int'(shutdown_o), 0);

      // Table walk: R4 R5 R8 R10
      for (int i = 0; i < NSTEP; i++) begin
         do_req(STEPS[i].wr, STEPS[i].addr, STEPS[i].data);
         chk($sformatf("R4/R5 wiper step %0d", i), int'(wiper_code_o), int'(STEPS[i].exp_wiper));
         if (!STEPS[i].wr) begin
            chk($sformatf("R8/R10 read data step %0d", i), int'(rd_data_o), int'(STEPS[i].exp_rd));
            chk($sformatf("R10 read valid step %0d", i), int'(rd_valid_o), 1);
         end else begin
            chk($sformatf("R10 no valid on write step %0d", i), int'(rd_valid_o), 0);
         end
      end

      // R6/R7: armed write of 00h commits on chip-select rise
      pulse_cs();
      do_req(1'b0, 2'b10, 8'h00);
      chk("R6 busy bit set", int'(rd_data_o), 'h60);
      do_req(1'b1, 2'b00, 8'h33);
      chk("R7 wiper write dropped while busy", int'(wiper_code_o), 0);
      do_req(1'b1, 2'b10, 8'h80);
      do_req(1'b0, 2'b10, 8'h00);
      chk("R7 control write dropped while busy", int'(rd_data_o), 'h60);
      idle(WC);
      do_req(1'b0, 2'b10, 8'h00);
      chk("R6 busy cleared", int'(rd_data_o), 'h40);
      do_req(1'b0, 2'b00, 8'h00);
      chk("R6 retained code committed", int'(rd_data_o), 0);

      // R6: exact busy window length
      do_req(1'b1, 2'b00, 8'h2A);
      chk("R5 wiper loads with retained write", int'(wiper_code_o), 'h2A);
      pulse_cs();
      idle(WC - 1);
      do_req(1'b0, 2'b10, 8'h00);
      chk("R6 busy on last cycle", int'(rd_data_o), 'h60);
      do_req(1'b0, 2'b10, 8'h00);
      chk("R6 busy ends after WC cycles", int'(rd_data_o), 'h40);
      do_req(1'b0, 2'b00, 8'h00);
      chk("R6 second commit", int'(rd_data_o), 'h2A);

      // R9: shutdown from pin and from run bit
      shdn_pin_n = 1'b0;
      #1 chk("R9 pin shutdown", int'(shutdown_o), 1);
      chk("R9 code kept in shutdown", int'(wiper_code_o), 'h2A);
      @(negedge clk);
      do_req(1'b1, 2'b10, 8'hC0);
      do_req(1'b1, 2'b00, 8'h11);
      chk("R9 writes accepted in shutdown", int'(wiper_code_o), 'h11);
      do_req(1'b0, 2'b10, 8'h00);
      chk("R9 control readable in shutdown", int'(rd_data_o), 'hC0);
      shdn_pin_n = 1'b1;
      #1 chk("R9 pin release", int'(shutdown_o), 0);
      @(negedge clk);
      do_req(1'b1, 2'b10, 8'h80);
      chk("R9 run bit shutdown", int'(shutdown_o), 1);
      do_req(1'b1, 2'b10, 8'hC0);
      chk("R9 run bit release", int'(shutdown_o), 0);
      chk("R9 code after shutdown", int'(wiper_code_o), 'h11);

      // R11: volatile reset keeps retained code
      rst_n = 1'b0;
      idle(2);
      chk("R1 control reset", int'(wiper_code_o), 'h40);
      rst_n = 1'b1;
      idle(RC);
      chk("R11 recall of last commit", int'(wiper_code_o), 'h2A);
      do_req(1'b0, 2'b10, 8'h00);
      chk("R1 control default after reset", int'(rd_data_o), 'h40);
      ret_rst_n = 1'b0;
      idle(1);
      ret_rst_n = 1'b1;
      do_req(1'b0, 2'b00, 8'h00);
      chk("R11 factory code restored", int'(rd_data_o), FAC);

      report();
      $finish;
   end
endmodule